// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a MAC receive stream into memory buffers that software has prepared. Software builds a chain of four-word buffer descriptors in memory. It marks each one as owned by hardware and writes the address of the first one into a per-channel head register. For every incoming frame, the engine reads the descriptor at the channel's head. It checks the ownership flag and streams the frame words into the descriptor's buffer. It then writes the received byte count and status back into the descriptor with ownership cleared, and advances the head to the descriptor's next pointer.

Descriptor layout, in 32-bit words from the descriptor address:

- Word 0 is the next pointer.
- Word 1 is the buffer address.
- Word 2 is the buffer length, with buffer flags in its upper half.
- Word 3 is the received length in bits 15:0, with status in bits 31:16.

A finished descriptor raises a per-channel pending bit. The enabled pending bits drive a single interrupt line. Software clears a pending bit by writing the descriptor's address into the channel's acknowledge register. A null next pointer ends the chain: that descriptor is marked end-of-queue and the channel stops until software writes its head again. Frames that cannot be stored are discarded and counted, either because no owned descriptor is available or because the frame exceeds the programmed maximum length.

The register interface is write-only and word-indexed on `reg_addr`. Memory is reached through a simple port: a read issued in one cycle returns its data on `mem_rdata` in the next cycle, and a write completes in the cycle it is issued. A frame's byte count is four times its word count.

Top module: `rxdesc_dma`

## Requirements
- R1: After reset:
  - `int_pend`, `irq`, `ovr_cnt` and `long_cnt` are zero and `rx_ready` is low.
  - The maximum length register holds 1518.
  - The interrupt mask is zero and every channel is stopped.
- R2: An accepted frame's words are written to consecutive word addresses starting at the buffer address in descriptor word 1.
- R3: At the end of a frame the engine writes descriptor word 3:
  - The byte count goes in bits 15:0.
  - Bit 31 (start of packet) and bit 30 (end of packet) are set.
  - Bit 29 (owned by hardware) is cleared.
- R4: Head pointer register of channel c is register 0x08+c:
  - Writing a nonzero address there starts the channel at that descriptor.
  - After each write-back the head moves to the descriptor's next pointer.
  - A write-back whose next pointer is zero also sets bit 28 (end of queue) in word 3 and stops the channel.
  - A frame arriving for a stopped channel is discarded and `ovr_cnt` rises by one.
- R5: Each write-back sets `int_pend[c]` for its channel. `irq` is the registered OR of the pending bits whose mask bit is set.
- R6: Writing address A to acknowledge register 0x10+c clears `int_pend[c]` when A equals the channel's most recently written-back descriptor. Any other address leaves the bit unchanged.
- R7: If the fetched descriptor has bit 29 of word 3 clear:
  - The frame is discarded and `ovr_cnt` rises by one.
  - Nothing is written to the buffer.
  - The head stays put, so the same descriptor is retried on the next frame.
- R8: Maximum length register 0x01 (bits 15:0, byte units). A frame longer than this:
  - is not written back and raises no pending bit;
  - increments `long_cnt`;
  - leaves its descriptor owned by hardware for the next frame.
- R9: Writing ones to register 0x02 sets interrupt mask bits; writing ones to register 0x03 clears them. A pending bit with its mask bit clear does not drive `irq`.
- R10: Bit 0 of control register 0x00 enables reception. While it is zero, no new frame is started, and `rx_ready` stays low with the descriptor untouched.
- R11: When a write-back and a matching acknowledge land on the same channel in the same cycle, the write-back wins and the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |
| rx_last | input | 1 | Last word of frame |
| rx_chan | input | CH_W | Channel of the frame |
| rx_ready | output | 1 | Receive word accepted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |
| int_pend | output | NCH | Per-channel pending write-back |
| irq | output | 1 | Masked interrupt |
| ovr_cnt | output | CNT_W | Frames lost for want of an owned descriptor |
| long_cnt | output | CNT_W | Frames rejected for exceeding maximum length |

## Verification
The two functions that can coincide are these:

- a descriptor write-back setting a channel's pending bit;
- software acknowledging that channel's previous descriptor, which clears the same bit.

To force the overlap, the bench holds the acknowledge strobe asserted continuously with the earlier descriptor's address while a new frame is stored. The acknowledge is therefore certain to share a cycle with the write-back, without the bench having to predict that cycle. The test is judged by the pending bit after the frame: it must be set, because the write-back wins and the stale address no longer matches the most recent descriptor.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int HALF_W = 16;

  // status bit positions inside the upper half of descriptor word 3
  localparam int ST_SOP = 15;
  localparam int ST_EOP = 14;
  localparam int ST_OWN = 13;
  localparam int ST_EOQ = 12;

  // register word indices
  localparam int REG_CTRL    = 0;
  localparam int REG_MAXLEN  = 1;
  localparam int REG_IEN_SET = 2;
  localparam int REG_IEN_CLR = 3;
  localparam int REG_HEAD0   = 8;
  localparam int REG_ACK0    = 16;

  typedef enum logic [2:0] {
    E_IDLE,
    E_FETCH,
    E_DECIDE,
    E_DATA,
    E_WB,
    E_DRAIN
  } eng_state_t;
endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
  import rxd_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int ADDR_W     = 32,
  parameter int RA_W       = 6,
  parameter int MAXLEN_RST = 1518,
  parameter int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_we,
  input  logic [RA_W-1:0]             reg_addr,
  input  logic [31:0]                 reg_wdata,
  input  logic                        done,
  input  logic [CH_W-1:0]             done_ch,
  input  logic [ADDR_W-1:0]           done_next,
  output logic                        rx_en,
  output logic [HALF_W-1:0]           max_len,
  output logic [NCH-1:0]              ien,
  output logic [NCH-1:0][ADDR_W-1:0]  head,
  output logic [NCH-1:0]              run,
  output logic [NCH-1:0]              ack_hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en   <= 1'b0;
      max_len <= HALF_W'(MAXLEN_RST);
      ien     <= '0;
    end else if (reg_we) begin
      case (int'(reg_addr))
        REG_CTRL:    rx_en   <= reg_wdata[0];
        REG_MAXLEN:  max_len <= reg_wdata[HALF_W-1:0];
        REG_IEN_SET: ien     <= ien | reg_wdata[NCH-1:0];
        REG_IEN_CLR: ien     <= ien & ~reg_wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic head_wr;
    assign head_wr    = reg_we && (int'(reg_addr) == REG_HEAD0 + c);
    assign ack_hit[c] = reg_we && (int'(reg_addr) == REG_ACK0 + c);

    always_ff @(posedge clk) begin
      if (rst) begin
        head[c] <= '0;
        run[c]  <= 1'b0;
      end else if (head_wr) begin
        // software restart has priority over engine advance
        head[c] <= reg_wdata[ADDR_W-1:0];
        run[c]  <= (reg_wdata[ADDR_W-1:0] != '0);
      end else if (done && (done_ch == CH_W'(c))) begin
        head[c] <= done_next;
        run[c]  <= (done_next != '0);
      end
    end
  end
endmodule

// File: rtl/rxd_irq.sv
module rxd_irq #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 32,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [CH_W-1:0]   done_ch,
  input  logic [ADDR_W-1:0] done_addr,
  input  logic [NCH-1:0]    ack_hit,
  input  logic [31:0]       ack_data,
  input  logic [NCH-1:0]    ien,
  output logic [NCH-1:0]    pend,
  output logic              irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ADDR_W-1:0] last_desc;
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[c]   <= 1'b0;
        last_desc <= '0;
      end else if (done && (done_ch == CH_W'(c))) begin
        // a fresh completion outranks any acknowledge in the same cycle
        pend[c]   <= 1'b1;
        last_desc <= done_addr;
      end else if (ack_hit[c] && (ack_data[ADDR_W-1:0] == last_desc)) begin
        pend[c]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & ien);
  end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_en,
  input  logic [HALF_W-1:0]          max_len,
  input  logic [NCH-1:0][ADDR_W-1:0] head,
  input  logic [NCH-1:0]             run,
  input  logic                       rx_valid,
  input  logic [31:0]                rx_data,
  input  logic                       rx_last,
  input  logic [CH_W-1:0]            rx_chan,
  output logic                       rx_ready,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [31:0]                mem_wdata,
  input  logic [31:0]                mem_rdata,
  output logic                       done,
  output logic [CH_W-1:0]            done_ch,
  output logic [ADDR_W-1:0]          done_addr,
  output logic [ADDR_W-1:0]          done_next,
  output logic [CNT_W-1:0]           ovr_cnt,
  output logic [CNT_W-1:0]           long_cnt
);
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS) + 1;

  eng_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic [CH_W-1:0]   cur_ch;
  logic [ADDR_W-1:0] desc_addr;
  logic [ADDR_W-1:0] w_next;
  logic [ADDR_W-1:0] w_buf;
  logic [31:0]       w_stat;
  logic [HALF_W-1:0] blen;

  logic [HALF_W:0]   nb;
  logic              too_long;
  logic              ch_ok;
  logic [15:0]       wb_status;

  assign nb       = {1'b0, blen} + (HALF_W+1)'(4);
  assign too_long = nb > {1'b0, max_len};
  assign ch_ok    = (int'(rx_chan) < NCH) && run[rx_chan];

  always_comb begin
    wb_status         = '0;
    wb_status[ST_SOP] = 1'b1;
    wb_status[ST_EOP] = 1'b1;
    wb_status[ST_EOQ] = (w_next == '0);
  end

  always_comb begin
    rx_ready  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      E_FETCH: begin
        if (int'(idx) < DESC_WORDS) begin
          mem_req  = 1'b1;
          mem_addr = desc_addr + ADDR_W'({idx, 2'b00});
        end
      end
      E_DATA: begin
        rx_ready = 1'b1;
        if (rx_valid && !too_long) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = w_buf + ADDR_W'(blen);
          mem_wdata = rx_data;
        end
      end
      E_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + ADDR_W'(12);
        mem_wdata = {wb_status, blen};
      end
      E_DRAIN: rx_ready = 1'b1;
      default: ;
    endcase
  end

  assign done      = (state == E_WB);
  assign done_ch   = cur_ch;
  assign done_addr = desc_addr;
  assign done_next = w_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= E_IDLE;
      idx       <= '0;
      cur_ch    <= '0;
      desc_addr <= '0;
      w_next    <= '0;
      w_buf     <= '0;
      w_stat    <= '0;
      blen      <= '0;
      ovr_cnt   <= '0;
      long_cnt  <= '0;
    end else begin
      case (state)
        E_IDLE: begin
          if (rx_en && rx_valid) begin
            cur_ch <= rx_chan;
            if (ch_ok) begin
              desc_addr <= head[rx_chan];
              idx       <= '0;
              state     <= E_FETCH;
            end else begin
              ovr_cnt <= ovr_cnt + 1'b1;
              state   <= E_DRAIN;
            end
          end
        end
        E_FETCH: begin
          idx <= idx + 1'b1;
          case (int'(idx))
            1: w_next <= mem_rdata[ADDR_W-1:0];
            2: w_buf  <= mem_rdata[ADDR_W-1:0];
            4: w_stat <= mem_rdata;
            default: ;
          endcase
          if (int'(idx) == DESC_WORDS) state <= E_DECIDE;
        end
        E_DECIDE: begin
          blen <= '0;
          if (w_stat[HALF_W+ST_OWN]) begin
            state <= E_DATA;
          end else begin
            ovr_cnt <= ovr_cnt + 1'b1;
            state   <= E_DRAIN;
          end
        end
        E_DATA: begin
          if (rx_valid) begin
            if (too_long) begin
              long_cnt <= long_cnt + 1'b1;
              state    <= rx_last ? E_IDLE : E_DRAIN;
            end else begin
              blen <= nb[HALF_W-1:0];
              if (rx_last) state <= E_WB;
            end
          end
        end
        E_WB:    state <= E_IDLE;
        E_DRAIN: if (rx_valid && rx_last) state <= E_IDLE;
        default: state <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
  import rxd_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int ADDR_W     = 32,
  parameter int RA_W       = 6,
  parameter int CNT_W      = 16,
  parameter int MAXLEN_RST = 1518,
  parameter int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              rx_valid,
  input  logic [31:0]       rx_data,
  input  logic              rx_last,
  input  logic [CH_W-1:0]   rx_chan,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [NCH-1:0]    int_pend,
  output logic              irq,
  output logic [CNT_W-1:0]  ovr_cnt,
  output logic [CNT_W-1:0]  long_cnt
);
  logic                       rx_en;
  logic [HALF_W-1:0]          max_len;
  logic [NCH-1:0]             ien;
  logic [NCH-1:0][ADDR_W-1:0] head;
  logic [NCH-1:0]             run;
  logic [NCH-1:0]             ack_hit;
  logic                       eng_done;
  logic [CH_W-1:0]            eng_done_ch;
  logic [ADDR_W-1:0]          eng_done_addr;
  logic [ADDR_W-1:0]          eng_done_next;

  rxd_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .RA_W(RA_W), .MAXLEN_RST(MAXLEN_RST), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .done(eng_done), .done_ch(eng_done_ch), .done_next(eng_done_next),
    .rx_en(rx_en), .max_len(max_len), .ien(ien), .head(head), .run(run), .ack_hit(ack_hit)
  );

  rxd_engine #(.NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_engine (
    .clk(clk), .rst(rst), .rx_en(rx_en), .max_len(max_len), .head(head), .run(run),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_chan(rx_chan),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(eng_done), .done_ch(eng_done_ch), .done_addr(eng_done_addr), .done_next(eng_done_next),
    .ovr_cnt(ovr_cnt), .long_cnt(long_cnt)
  );

  rxd_irq #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_irq (
    .clk(clk), .rst(rst), .done(eng_done), .done_ch(eng_done_ch), .done_addr(eng_done_addr),
    .ack_hit(ack_hit), .ack_data(reg_wdata), .ien(ien), .pend(int_pend), .irq(irq)
  );
endmodule

// File: rtl/rxdesc_dma_chk.sv
module rxdesc_dma_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16,
  parameter int CH_W  = 1
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   int_pend,
  input logic             irq,
  input logic [CNT_W-1:0] ovr_cnt,
  input logic             rx_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_wdata,
  input logic             done,
  input logic [CH_W-1:0]  done_ch
);
  logic            done_q;
  logic [CH_W-1:0] done_ch_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= 1'b0;
      done_ch_q <= '0;
    end else begin
      done_q    <= done;
      done_ch_q <= done_ch;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (int_pend == '0 && !irq && ovr_cnt == '0));

  // R3
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_req && mem_we && mem_wdata[31:29] == 3'b110));

  // R5
  done_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> int_pend[done_ch_q]);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|int_pend));

  // R7
  ovr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_cnt != $past(ovr_cnt)) |-> (ovr_cnt == $past(ovr_cnt) + 1'b1));

  // R10
  ready_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> !(mem_req && !mem_we));
endmodule

bind rxdesc_dma rxdesc_dma_chk #(.NCH(NCH), .CNT_W(CNT_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .int_pend(int_pend), .irq(irq), .ovr_cnt(ovr_cnt),
  .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .done(eng_done), .done_ch(eng_done_ch)
);

// File: tb/test_rxdesc_dma.sv
`timescale 1ns/1ps
module test_rxdesc_dma;
  localparam int NCH = 2;
  localparam int MW  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_last = 1'b0;
  logic        rx_chan = 1'b0;
  logic        rx_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  int_pend;
  logic        irq;
  logic [15:0] ovr_cnt, long_cnt;

  logic [31:0] mem [MW];
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rxdesc_dma i_rxdesc_dma (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_chan(rx_chan),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .int_pend(int_pend), .irq(irq),
    .ovr_cnt(ovr_cnt), .long_cnt(long_cnt)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int ch, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = seed + 32'(i); rx_last = (i == n-1); rx_chan = ch[0];
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  function automatic logic [31:0] rd(input int byte_addr);
    return mem[byte_addr/4];
  endfunction

  task automatic put_desc(input int a, input int nxt, input int buf_a, input logic [31:0] st);
    mem[a/4]   = 32'(nxt);
    mem[a/4+1] = 32'(buf_a);
    mem[a/4+2] = 32'h0000_0040;
    mem[a/4+3] = st;
  endtask

  task automatic t_reset;
    check("R1 int_pend", 32'(int_pend), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 ovr_cnt", 32'(ovr_cnt), 0);
    check("R1 long_cnt", 32'(long_cnt), 0);
    check("R1 rx_ready", 32'(rx_ready), 0);
  endtask

  task automatic t_basic;
    send_frame(0, 3, 32'h1111_0000);
    idle(6);
    check("R2 word0", rd(32'h400), 32'h1111_0000);
    check("R2 word2", rd(32'h408), 32'h1111_0002);
    check("R3 status", rd(32'h10C), 32'hC000_000C);
    check("R5 pend", 32'(int_pend), 32'h1);
    check("R5 irq", 32'(irq), 1);
  endtask

  task automatic t_ack;
    reg_wr(16, 32'h110); idle(2);
    check("R6 wrong ack ignored", 32'(int_pend), 32'h1);
    reg_wr(16, 32'h100); idle(2);
    check("R6 ack clears", 32'(int_pend), 0);
    check("R6 irq low", 32'(irq), 0);
  endtask

  task automatic t_chain_eoq;
    send_frame(0, 2, 32'h2222_0000);
    idle(6);
    check("R4 next buffer", rd(32'h500), 32'h2222_0000);
    check("R4 eoq status", rd(32'h11C), 32'hD000_0008);
    reg_wr(16, 32'h110); idle(2);
    send_frame(0, 2, 32'h3333_0000);
    idle(6);
    check("R4 stopped drop", 32'(ovr_cnt), 1);
    check("R4 buffer intact", rd(32'h400), 32'h1111_0000);
    check("R4 no pend", 32'(int_pend), 0);
  endtask

  task automatic t_restart_own;
    mem[32'h10C/4] = 32'h2000_0000;
    reg_wr(8, 32'h100);
    send_frame(0, 1, 32'h4444_0000);
    idle(6);
    check("R4 restart data", rd(32'h400), 32'h4444_0000);
    check("R4 restart status", rd(32'h10C), 32'hC000_0004);
    reg_wr(16, 32'h100);
    send_frame(0, 2, 32'h5555_0000);
    idle(6);
    check("R7 not owned count", 32'(ovr_cnt), 2);
    check("R7 buffer intact", rd(32'h500), 32'h2222_0000);
    mem[32'h11C/4] = 32'h2000_0000;
    send_frame(0, 2, 32'h6666_0000);
    idle(6);
    check("R7 retry data", rd(32'h500), 32'h6666_0000);
    check("R7 retry status", rd(32'h11C), 32'hD000_0008);
    reg_wr(16, 32'h110); idle(2);
  endtask

  task automatic t_oversize;
    reg_wr(1, 32'd8);
    reg_wr(9, 32'h140);
    send_frame(1, 3, 32'h7777_0000);
    idle(6);
    check("R8 long count", 32'(long_cnt), 1);
    check("R8 still owned", rd(32'h14C), 32'h2000_0000);
    check("R8 no pend", 32'(int_pend), 0);
    send_frame(1, 2, 32'h8888_0000);
    idle(6);
    check("R8 fits data", rd(32'h600), 32'h8888_0000);
    check("R8 fits status", rd(32'h14C), 32'hD000_0008);
    check("R8 pend ch1", 32'(int_pend), 32'h2);
    reg_wr(1, 32'd1518);
  endtask

  task automatic t_mask;
    reg_wr(3, 32'h2); idle(2);
    check("R9 masked irq", 32'(irq), 0);
    check("R9 pend kept", 32'(int_pend), 32'h2);
    reg_wr(2, 32'h2); idle(2);
    check("R9 unmasked irq", 32'(irq), 1);
    reg_wr(17, 32'h140); idle(2);
    check("R9 ack ch1", 32'(int_pend), 0);
    check("R9 irq off", 32'(irq), 0);
  endtask

  task automatic t_disable;
    reg_wr(0, 32'h0);
    reg_wr(8, 32'h180);
    fork
      send_frame(0, 2, 32'h9999_0000);
      begin
        idle(20); #2;
        check("R10 stalled", 32'(rx_ready), 0);
        check("R10 desc untouched", rd(32'h18C), 32'h2000_0000);
        reg_wr(0, 32'h1);
      end
    join
    idle(6);
    check("R10 after enable data", rd(32'h700), 32'h9999_0000);
    check("R10 after enable status", rd(32'h18C), 32'hC000_0008);
    check("R10 pend", 32'(int_pend), 32'h1);
  endtask

  task automatic t_collide;
    fork
      send_frame(0, 3, 32'hAAAA_0000);
      begin
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'd16; reg_wdata = 32'h180;
        repeat (40) @(negedge clk);
        reg_we = 1'b0;
      end
    join
    idle(4);
    check("R11 completion wins", 32'(int_pend), 32'h1);
    check("R11 status", rd(32'h19C), 32'hD000_000C);
    reg_wr(16, 32'h190); idle(2);
    check("R11 later ack", 32'(int_pend), 0);
  endtask

  initial begin
    for (int i = 0; i < MW; i++) mem[i] = '0;
    put_desc(32'h100, 32'h110, 32'h400, 32'h2000_0000);
    put_desc(32'h110, 0,       32'h500, 32'h2000_0000);
    put_desc(32'h140, 0,       32'h600, 32'h2000_0000);
    put_desc(32'h180, 32'h190, 32'h700, 32'h2000_0000);
    put_desc(32'h190, 0,       32'h800, 32'h2000_0000);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle(1);
    t_reset();
    reg_wr(2, 32'h3);
    reg_wr(0, 32'h1);
    reg_wr(8, 32'h100);
    t_basic();
    t_ack();
    t_chain_eoq();
    t_restart_own();
    t_oversize();
    t_mask();
    t_disable();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule